// File: doc/BRIEF.md
# Counter-Driven Serial Shift Engine

This block is a serial shift engine for a synchronous serial link. It is built around one data register that shifts either a full 16-bit word or only its low byte, as a control bit chooses at run time. The host loads the data register, then writes a bit count. Writing a nonzero count starts a transfer of exactly that many bits. Each bit moves one position out on the serial data output and one position in from the serial data input. The received bits fill the opposite end of the same register, so the received word is read back from where the transmit word was loaded.

As master, the engine makes its own serial clock. The clock comes from a power-of-two prescaler that counts either core clock cycles or pulses on an auxiliary tick input. As slave, the engine follows edges of an external serial clock. Clock polarity and clock phase choose the idle level of the clock and which edge moves the data. A completion flag rises when the count reaches zero. A nonzero count write clears the flag, unless a keep bit is set; in that case only a write to the clear address clears it. An interrupt output follows the flag when it is enabled. A software-reset bit freezes the engine.

Top module: `ser_shift_engine`

## Requirements
- R1: With control bit 6 (wide) at 1 all 16 bits shift. With wide at 0 only bits 7:0 shift, bits 15:8 keep their value, and the outgoing bit is bit 7 (MSB-first) or bit 0 (LSB-first).
- R2: A write of N (1 to 16) to address 2, bits 4:0, starts a transfer of exactly N bits. As master it gives exactly N serial clock pulses, which is 2N level changes on sclk_out.
- R3: `done` rises when the bit count reaches zero. Reading address 2 then returns the count in bits 4:0 and the flag in bit 8, giving 0x0100.
- R4: A nonzero count write clears `done` at the same clock edge when control bit 7 (keep) is 0. With keep at 1 the flag stays set and no bits move. A write to address 3 then clears it and lets the transfer run.
- R5: As master, sclk_out toggles only while `done` is 0, the count is above 0 and the engine is not held. At all other times it sits at the polarity level.
- R6: Control bit 2 (lsb_first) picks the bit order. At 1 bit 0 leaves first and received bits enter at the top of the active width. At 0 the top bit leaves first and received bits enter at bit 0.
- R7: Control bit 5 (cpol) is the idle clock level. With control bit 4 (cpha) at 0, sdo holds the first bit before the leading edge, sdi is captured on leading edges and sdo changes on trailing edges. With cpha at 1, sdo changes on leading edges and sdi is captured on trailing edges.
- R8: Control bits 11:9 (div) set a prescale of 2^div. With the core-clock source an N-bit master transfer raises `done` exactly 2·N·2^div cycles after the edge that samples the count write.
- R9: With control bit 12 (src_aux) at 1 the prescaler counts only cycles where aux_tick is 1. A master transfer then needs exactly 2·N·2^div such pulses.
- R10: While control bit 0 (hold) is 1, the count, the data register and `done` do not change without a host write. The reset value of the control register is 0x0001.
- R11: sdo_oe equals control bit 3 (sdo_en).
- R12: irq is 1 exactly when control bit 8 (irq_en) and `done` are both 1.
- R13: With control bit 1 (master) at 0, sclk_oe is 0 and the engine shifts on edges of sclk_in, following R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 data, 2 count, 3 flag clear |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| aux_tick | input | 1 | Alternative prescaler source pulse |
| sclk_in | input | 1 | Serial clock from a remote master |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Serial clock driver enable (master) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data driver enable |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
As master, `done` is due exactly 2·N·2^div cycles after the edge that samples the count write. The bench samples it one falling edge before that edge, where it must be 0, and at the falling edge right after it, where it must be 1. The same count applies to auxiliary pulses. A cleared flag after a count write, the reset-bit edge and the flag-clear write are each checked at the first falling edge after the sampling edge. In slave mode the bench moves sclk_in itself and waits three cycles after every change before it drives sdi or reads sdo, so each result is sampled well after the single register stage that it passes through.

// File: rtl/sse_pkg.sv
package sse_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int CNT_W  = 5;
    localparam int DIV_W  = 3;
    localparam int ADDR_W = 2;
    localparam int CTL_W  = 13;

    typedef enum logic [ADDR_W-1:0] {
        A_CTL  = 2'd0,
        A_DATA = 2'd1,
        A_CNT  = 2'd2,
        A_CLR  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             src_aux;
        logic [DIV_W-1:0] div;
        logic             irq_en;
        logic             keep_flag;
        logic             wide;
        logic             cpol;
        logic             cpha;
        logic             sdo_en;
        logic             lsb_first;
        logic             master;
        logic             hold_rst;
    } ctl_t;

    localparam ctl_t CTL_RESET = ctl_t'(13'h0001);

    // bit that leaves the register next
    function automatic logic out_of(input logic [DATA_W-1:0] d,
                                    input logic wide, input logic lsb);
        if (lsb)
            return d[0];
        return wide ? d[DATA_W-1] : d[BYTE_W-1];
    endfunction

    // one shift step with a new bit entering the far end
    function automatic logic [DATA_W-1:0] step_word(input logic [DATA_W-1:0] d,
                                                     input logic wide, input logic lsb,
                                                     input logic in_bit);
        logic [DATA_W-1:0] r;
        r = d;
        if (wide)
            r = lsb ? {in_bit, d[DATA_W-1:1]} : {d[DATA_W-2:0], in_bit};
        else
            r[BYTE_W-1:0] = lsb ? {in_bit, d[BYTE_W-1:1]} : {d[BYTE_W-2:0], in_bit};
        return r;
    endfunction

endpackage

// File: rtl/sse_prescaler.sv
module sse_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_aux,
    input  logic             aux_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = (1 << DIV_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          src_en;

    assign lim    = (CW'(1) << div) - CW'(1);
    assign src_en = src_aux ? aux_tick : 1'b1;
    assign tick   = run && src_en && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (src_en)
            cnt <= (cnt == lim) ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/sse_shifter.sv
module sse_shifter
    import sse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              wide,
    input  logic              lsb_first,
    input  logic              in_bit,
    output logic [DATA_W-1:0] data,
    output logic              out_bit
);
    assign out_bit = out_of(data, wide, lsb_first);

    always_ff @(posedge clk) begin
        if (rst)
            data <= '0;
        else if (load)
            data <= load_val;
        else if (shift_en)
            data <= step_word(data, wide, lsb_first, in_bit);
    end
endmodule

// File: rtl/sse_sequencer.sv
module sse_sequencer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_rst,
    input  logic             master,
    input  logic             cpha,
    input  logic             cpol,
    input  logic             keep_flag,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    input  logic             tick,
    input  logic             sclk_in,
    input  logic             out_bit,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             running,
    output logic             shift_en,
    output logic             sclk_lvl,
    output logic             sdo_q
);
    logic phase;
    logic sclk_in_q;
    logic sclk_chg;
    logic lead;
    logic trail;
    logic change_ev;

    assign running  = !hold_rst && !flag && (cnt != '0);
    assign sclk_chg = sclk_in ^ sclk_in_q;

    always_comb begin
        if (master) begin
            lead  = running && tick && !phase;
            trail = running && tick && phase;
        end else begin
            lead  = running && sclk_chg && (sclk_in != cpol);
            trail = running && sclk_chg && (sclk_in == cpol);
        end
    end

    assign shift_en  = cpha ? trail : lead;
    assign change_ev = cpha ? lead : trail;
    assign sclk_lvl  = cpol ^ (phase & running);

    always_ff @(posedge clk) begin
        if (rst)
            sclk_in_q <= 1'b0;
        else
            sclk_in_q <= sclk_in;
    end

    always_ff @(posedge clk) begin
        if (rst || hold_rst || !master || !running)
            phase <= 1'b0;
        else if (lead)
            phase <= 1'b1;
        else if (trail)
            phase <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt_load)
            cnt <= cnt_val;
        else if (trail)
            cnt <= cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (cnt_load && (cnt_val != '0) && !keep_flag)
            flag <= 1'b0;
        else if (flag_clr)
            flag <= 1'b0;
        else if (trail && !cnt_load && (cnt == CNT_W'(1)))
            flag <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sdo_q <= 1'b0;
        else if (!running || change_ev)
            sdo_q <= out_bit;
    end
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
    import sse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              aux_tick,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              done,
    output logic              irq
);
    ctl_t              ctl;
    logic [DATA_W-1:0] shift_data;
    logic [CNT_W-1:0]  cnt;
    logic              flag;
    logic              running;
    logic              shift_en;
    logic              out_bit;
    logic              tick;
    logic              sdo_q;
    logic              sclk_lvl;

    logic wr_ctl, wr_dat, wr_cnt, wr_clr;
    assign wr_ctl = wr_en && (wr_addr == A_CTL);
    assign wr_dat = wr_en && (wr_addr == A_DATA);
    assign wr_cnt = wr_en && (wr_addr == A_CNT);
    assign wr_clr = wr_en && (wr_addr == A_CLR);

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= CTL_RESET;
        else if (wr_ctl)
            ctl <= ctl_t'(wr_data[CTL_W-1:0]);
    end

    sse_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (running && ctl.master),
        .src_aux  (ctl.src_aux),
        .aux_tick (aux_tick),
        .div      (ctl.div),
        .tick     (tick)
    );

    sse_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hold_rst  (ctl.hold_rst),
        .master    (ctl.master),
        .cpha      (ctl.cpha),
        .cpol      (ctl.cpol),
        .keep_flag (ctl.keep_flag),
        .cnt_load  (wr_cnt),
        .cnt_val   (wr_data[CNT_W-1:0]),
        .flag_clr  (wr_clr),
        .tick      (tick),
        .sclk_in   (sclk_in),
        .out_bit   (out_bit),
        .cnt       (cnt),
        .flag      (flag),
        .running   (running),
        .shift_en  (shift_en),
        .sclk_lvl  (sclk_lvl),
        .sdo_q     (sdo_q)
    );

    sse_shifter u_shf (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_dat),
        .load_val  (wr_data),
        .shift_en  (shift_en),
        .wide      (ctl.wide),
        .lsb_first (ctl.lsb_first),
        .in_bit    (sdi),
        .data      (shift_data),
        .out_bit   (out_bit)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTL:   rd_data[CTL_W-1:0] = ctl;
            A_DATA:  rd_data = shift_data;
            A_CNT:   begin
                rd_data[CNT_W-1:0] = cnt;
                rd_data[8]         = flag;
            end
            default: rd_data = '0;
        endcase
    end

    assign sclk_out = sclk_lvl;
    assign sclk_oe  = ctl.master;
    assign sdo      = sdo_q;
    assign sdo_oe   = ctl.sdo_en;
    assign done     = flag;
    assign irq      = ctl.irq_en & flag;
endmodule

// File: rtl/sse_checker.sv
module sse_checker
    import sse_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  cnt_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              done,
    input logic              irq,
    input logic [BYTE_W-1:0] data_hi,
    input logic              sclk_out,
    input logic              master,
    input logic              cpol,
    input logic              wide,
    input logic              keep_flag,
    input logic              hold_rst
);
    logic cnt_wr, dat_wr;
    assign cnt_wr = wr_en && (wr_addr == A_CNT);
    assign dat_wr = wr_en && (wr_addr == A_DATA);

    p_hi_byte_r1: assert property (@(posedge clk) disable iff (rst)
        (!wide && !dat_wr) |=> (data_hi == $past(data_hi)));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) - CNT_W'(1)))));

    p_done_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt == '0));

    p_autoclr_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && (cnt_wdata != '0) && !keep_flag) |=> !done);

    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && keep_flag && done) |=> done);

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (master && (done || (cnt == '0) || hold_rst)) |-> (sclk_out == cpol));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (hold_rst && !wr_en) |=> ($stable(cnt) && $stable(done) && $stable(data_hi)));

    p_irq_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);
endmodule

bind ser_shift_engine sse_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cnt_wdata (wr_data[CNT_W-1:0]),
    .cnt       (cnt),
    .done      (done),
    .irq       (irq),
    .data_hi   (shift_data[DATA_W-1:BYTE_W]),
    .sclk_out  (sclk_out),
    .master    (ctl.master),
    .cpol      (ctl.cpol),
    .wide      (ctl.wide),
    .keep_flag (ctl.keep_flag),
    .hold_rst  (ctl.hold_rst)
);

// File: tb/tb_ser_shift_engine.sv
module tb_ser_shift_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        aux_tick = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sdo, sdo_oe, done, irq;
    logic        loopback = 1'b1;
    logic        sdi_bench = 1'b0;
    logic        sdi;

    int total = 0;
    int bad = 0;
    int toggles = 0;
    bit finished = 0;
    logic prev_sclk = 1'b0;

    always #4 clk = ~clk;
    assign sdi = loopback ? sdo : sdi_bench;

    ser_shift_engine dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .aux_tick(aux_tick), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .done(done), .irq(irq)
    );

    always @(posedge clk) begin
        #2;
        if (sclk_out !== prev_sclk) toggles++;
        prev_sclk = sclk_out;
    end

    function automatic logic m_out(input logic [15:0] d, input bit wide, input bit lsb);
        if (lsb) return d[0];
        return wide ? d[15] : d[7];
    endfunction

    function automatic logic [15:0] m_shift(input logic [15:0] d, input bit wide,
                                            input bit lsb, input logic b);
        logic [15:0] r;
        r = d;
        if (wide) begin
            if (lsb) r = {b, d[15:1]}; else r = {d[14:0], b};
        end else begin
            if (lsb) r[7:0] = {b, d[7:1]}; else r[7:0] = {d[6:0], b};
        end
        return r;
    endfunction

    function automatic logic [15:0] mk_ctl(input bit src, input int div, input bit ien,
                                           input bit keep, input bit wide, input bit cpol,
                                           input bit cpha, input bit oe, input bit lsb,
                                           input bit mst, input bit hold);
        return {3'b0, src, 3'(div), ien, keep, wide, cpol, cpha, oe, lsb, mst, hold};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [15:0] loop_model(input logic [15:0] d, input int n,
                                               input bit wide, input bit lsb);
        logic [15:0] r;
        r = d;
        for (int i = 0; i < n; i++) r = m_shift(r, wide, lsb, m_out(r, wide, lsb));
        return r;
    endfunction

    // master loopback transfer with exact completion timing
    task automatic run_master(input logic [15:0] c, input logic [15:0] d, input int n);
        logic [15:0] v;
        int t0, r;
        bit wide, lsb;
        wide = c[6]; lsb = c[2]; r = 1 << c[11:9];
        loopback = 1'b1;
        wr(2'd0, c);
        chk("R11 sdo_oe", {31'b0, sdo_oe}, {31'b0, c[3]});
        wr(2'd1, d);
        t0 = toggles;
        wr(2'd2, 16'(n));
        repeat (2 * n * r - 1) @(negedge clk);
        chk("R8 done early", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R3 R8 done due", {31'b0, done}, 32'd1);
        chk("R2 sclk changes", toggles - t0, 32'(2 * n));
        chk("R5 sclk idle", {31'b0, sclk_out}, {31'b0, c[5]});
        rd(2'd1, v);
        chk("R1 R6 R7 data", {16'b0, v}, {16'b0, loop_model(d, n, wide, lsb)});
        rd(2'd2, v);
        chk("R3 count read", {16'b0, v}, 32'h0100);
        chk("R12 irq", {31'b0, irq}, {31'b0, c[8]});
    endtask

    // slave transfer: bench drives sclk_in and sdi, collects sdo
    task automatic run_slave(input bit cpol, input bit cpha, input bit lsb, input bit wide,
                             input logic [15:0] d, input logic [15:0] rxw, input int n);
        logic [15:0] m, v;
        logic [31:0] got, exp;
        got = '0; exp = '0; m = d;
        loopback = 1'b0;
        sclk_in = cpol;
        wr(2'd0, mk_ctl(0, 0, 0, 0, wide, cpol, cpha, 1, lsb, 0, 0));
        chk("R13 sclk_oe", {31'b0, sclk_oe}, 32'd0);
        wr(2'd1, d);
        wr(2'd2, 16'(n));
        for (int i = 0; i < n; i++) begin
            exp[i] = m_out(m, wide, lsb);
            m = m_shift(m, wide, lsb, rxw[i]);
            @(negedge clk); sdi_bench = rxw[i];
            repeat (3) @(negedge clk);
            if (!cpha) got[i] = sdo;
            sclk_in = ~cpol;
            repeat (3) @(negedge clk);
            if (cpha) got[i] = sdo;
            sclk_in = cpol;
            repeat (3) @(negedge clk);
        end
        chk("R13 R7 sdo bits", got, exp);
        rd(2'd1, v);
        chk("R13 R6 slave data", {16'b0, v}, {16'b0, m});
        chk("R13 R3 slave done", {31'b0, done}, 32'd1);
        loopback = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, d0;
        int t0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(2'd0, v); chk("R10 ctl reset", {16'b0, v}, 32'h0001);
        rd(2'd2, v); chk("R3 count reset", {16'b0, v}, 32'h0);
        chk("R12 irq reset", {31'b0, irq}, 32'd0);
        chk("R13 sclk_oe reset", {31'b0, sclk_oe}, 32'd0);

        // R10 hold: nothing moves while held
        wr(2'd0, mk_ctl(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, 1));
        wr(2'd1, 16'hA5C3);
        t0 = toggles;
        wr(2'd2, 16'd8);
        repeat (30) @(negedge clk);
        chk("R10 no sclk held", toggles - t0, 32'd0);
        rd(2'd2, v); chk("R10 count held", {16'b0, v}, 32'd8);
        rd(2'd1, v); chk("R10 data held", {16'b0, v}, 32'hA5C3);
        wr(2'd0, mk_ctl(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, 0));
        repeat (15) @(negedge clk);
        chk("R10 release early", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R10 release done", {31'b0, done}, 32'd1);
        rd(2'd1, v); chk("R10 data after", {16'b0, v}, {16'b0, loop_model(16'hA5C3, 8, 1, 0)});
        d0 = v;

        // R4 keep flag: reload does not clear or start
        wr(2'd0, mk_ctl(0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0));
        chk("R11 sdo_oe off", {31'b0, sdo_oe}, 32'd0);
        t0 = toggles;
        wr(2'd2, 16'd5);
        chk("R4 keep flag", {31'b0, done}, 32'd1);
        repeat (20) @(negedge clk);
        chk("R5 no sclk while done", toggles - t0, 32'd0);
        rd(2'd1, v); chk("R4 data frozen", {16'b0, v}, {16'b0, d0});
        rd(2'd2, v); chk("R4 count kept", {16'b0, v}, 32'h0105);
        chk("R12 irq off", {31'b0, irq}, 32'd0);
        wr(2'd3, 16'd0);
        repeat (9) @(negedge clk);
        chk("R4 clear early", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R4 clear done", {31'b0, done}, 32'd1);

        // R4 auto clear
        wr(2'd0, mk_ctl(0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 0));
        chk("R12 irq on", {31'b0, irq}, 32'd1);
        wr(2'd2, 16'd3);
        chk("R4 auto clear", {31'b0, done}, 32'd0);
        chk("R12 irq follows", {31'b0, irq}, 32'd0);
        repeat (6) @(negedge clk);
        chk("R4 reload done", {31'b0, done}, 32'd1);

        // R1 byte mode keeps high byte
        run_master(mk_ctl(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0), 16'h3C81, 8);
        run_master(mk_ctl(0, 2, 1, 0, 0, 1, 1, 0, 1, 1, 0), 16'hF00D, 5);

        // R9 auxiliary source: 2*4*2 pulses
        wr(2'd0, mk_ctl(1, 1, 0, 0, 1, 0, 1, 1, 0, 1, 0));
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'd4);
        repeat (10) @(negedge clk);
        chk("R9 no pulses no progress", {31'b0, done}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            if (i == 15) chk("R9 pulse early", {31'b0, done}, 32'd0);
            aux_tick = 1'b1; @(negedge clk);
            aux_tick = 1'b0; @(negedge clk);
        end
        chk("R9 pulse done", {31'b0, done}, 32'd1);
        rd(2'd1, v); chk("R9 data", {16'b0, v}, {16'b0, loop_model(16'h1234, 4, 1, 0)});

        // R13 slave mode, all clock modes
        run_slave(0, 0, 0, 1, 16'hC35A, 16'h9E17, 16);
        run_slave(1, 1, 1, 1, 16'h0FF1, 16'h6A2B, 11);
        run_slave(0, 1, 0, 0, 16'hBE42, 16'h00D6, 8);
        run_slave(1, 0, 1, 0, 16'h7711, 16'h0093, 6);

        // random master transfers
        for (int k = 0; k < 40; k++) begin
            logic [15:0] c;
            int n;
            c = mk_ctl(0, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), 0,
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                       bit'($urandom_range(0, 1)), 1, 0);
            n = int'($urandom_range(1, 16));
            run_master(c, 16'($urandom), n);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule